// File: doc/BRIEF.md
# Double-Buffered Serial-to-Parallel Output Register

This block turns a serial bit stream into a parallel word and presents that word on outputs that can be placed in high impedance. Bits enter a shift chain on the rising edge of a shift clock. The word is then copied into a separate holding register on the rising edge of an independent latch clock. The parallel outputs show the holding register, so the word a consumer sees stays steady while the next word is being shifted in.

An active-low clear acts at once on the shift chain only. It does not need a clock edge, and it leaves the holding register as it was. An active-low output enable either drives the parallel outputs from the holding register or releases them to high impedance. A cascade output always drives the last shift stage. Feeding it into the serial input of a second instance makes a longer chain.

If both clocks come from one net, the holding register takes the chain contents from before the shift on that same edge, so it runs one shift behind. The holding register has no reset. Its value is unspecified until the first rising latch-clock edge.

Top module: `dbl_buf_sipo`

## Requirements
- R1: On a rising `shift_clk` edge while `clr_n` is high, stage 0 takes `ser_in` and each stage k>0 takes the old value of stage k-1.
- R2: A falling `shift_clk` edge leaves every shift stage unchanged, including when `ser_in` changes while `shift_clk` is high.
- R3: On a rising `latch_clk` edge the holding register takes the whole shift chain, so `par_q[k]` equals stage k (`par_q[0]` is stage 0, the most recently entered bit).
- R4: The holding register changes only on a rising `latch_clk` edge. Falling `latch_clk` edges and all `shift_clk` edges leave `par_q` unchanged.
- R5: While `clr_n` is low, all shift stages are 0 immediately, with no clock edge needed, and rising `shift_clk` edges have no effect.
- R6: The clear leaves the holding register, and so `par_q`, unchanged.
- R7: With `oe_n` = 1, every bit of `par_q` is high impedance. With `oe_n` = 0, `par_q` drives the holding register.
- R8: `ser_out` always drives the last shift stage (stage WIDTH-1), whatever the value of `oe_n`.
- R9: When `shift_clk` and `latch_clk` rise together, the holding register takes the chain contents from before that edge's shift.
- R10: Two instances chained through `ser_out` to `ser_in` form a 2×WIDTH-bit chain. After 2×WIDTH shifts of word w, sent from its most significant bit down to bit 0, and one latch, the first instance shows w[WIDTH-1:0] and the second shows w[2·WIDTH-1:WIDTH].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_in | input | 1 | Serial data, sampled on rising `shift_clk` |
| shift_clk | input | 1 | Shift chain clock, rising edge active |
| latch_clk | input | 1 | Holding register clock, rising edge active |
| clr_n | input | 1 | Asynchronous clear of the shift chain, active low |
| oe_n | input | 1 | Parallel output enable, active low (1 = high impedance) |
| par_q | output | WIDTH | Parallel outputs from the holding register, tri-state |
| ser_out | output | 1 | Cascade output from the last shift stage, never tri-stated |

## Verification
The bench places a pull-up on one instance's parallel net and a pull-down on the other's, then loads each with a word whose bits are the opposite of its pull. A driver that failed to release would read as the held data instead of the pull value. It ties both clocks together and expects the word from before the shift; an ordering mistake would show the new word a cycle early. It pulses the clear between latch edges. A clear that also reached the holding register would blank `par_q`, and a clear that did not override the clock would let ones into the chain. It changes `ser_in` while `shift_clk` is high and holds `latch_clk` high during a shift, so a design that captured on the wrong edge or in level mode would drift from the expected word.

// File: rtl/sipo_pkg.sv
package sipo_pkg;

  parameter int unsigned SIPO_WIDTH_DEF = 8;

  typedef enum logic {
    OUT_DRIVE = 1'b0,
    OUT_FLOAT = 1'b1
  } out_mode_e;

endpackage

// File: rtl/sipo_shift_stage.sv
module sipo_shift_stage #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             shift_clk,
  input  logic             clr_n,
  input  logic             ser_in,
  output logic [WIDTH-1:0] stage_q
);

  logic [WIDTH-1:0] stage_d;
  logic             clr_mark;

  // next state: stage 0 from the serial pin, the rest from their neighbour
  for (genvar k = 0; k < WIDTH; k++) begin : g_next
    if (k == 0) begin : g_head
      assign stage_d[k] = ser_in;
    end else begin : g_body
      assign stage_d[k] = stage_q[k-1];
    end
  end

  always_ff @(posedge shift_clk or negedge clr_n) begin
    if (!clr_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  // notes that a clear happened since the previous shift edge
  always_ff @(posedge shift_clk or negedge clr_n) begin
    if (!clr_n) begin
      clr_mark <= 1'b1;
    end else begin
      clr_mark <= 1'b0;
    end
  end

  assert_shift_R1: assert property (@(posedge shift_clk) disable iff (!clr_n)
    !clr_mark |-> stage_q == {$past(stage_q[WIDTH-2:0]), $past(ser_in)});

  assert_clear_zero_R5: assert property (@(posedge shift_clk) disable iff (!clr_n)
    clr_mark |-> stage_q == '0);

endmodule

// File: rtl/sipo_hold_reg.sv
module sipo_hold_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             latch_clk,
  input  logic             clr_n,
  input  logic [WIDTH-1:0] stage_in,
  output logic [WIDTH-1:0] hold_q
);

  logic [WIDTH-1:0] hold_d;

  always_comb begin
    hold_d = stage_in;
  end

  // no reset: contents are defined by the first latch edge
  always_ff @(posedge latch_clk) begin
    hold_q <= hold_d;
  end

  assert_copy_R3: assert property (@(posedge latch_clk) disable iff (!clr_n)
    1'b1 |=> hold_q == $past(stage_in));

endmodule

// File: rtl/sipo_tri_drive.sv
module sipo_tri_drive
  import sipo_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             oe_n,
  input  logic [WIDTH-1:0] hold_q,
  output wire  [WIDTH-1:0] par_q
);

  out_mode_e mode;

  assign mode = out_mode_e'(oe_n);

  for (genvar k = 0; k < WIDTH; k++) begin : g_pad
    assign par_q[k] = (mode == OUT_FLOAT) ? 1'bz : hold_q[k];
  end

endmodule

// File: rtl/dbl_buf_sipo.sv
module dbl_buf_sipo
  import sipo_pkg::*;
#(
  parameter int unsigned WIDTH = SIPO_WIDTH_DEF
) (
  input  logic             ser_in,
  input  logic             shift_clk,
  input  logic             latch_clk,
  input  logic             clr_n,
  input  logic             oe_n,
  output wire  [WIDTH-1:0] par_q,
  output logic             ser_out
);

  localparam int unsigned LAST = WIDTH - 1;

  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] hold_q;
  logic             casc_mark;

  sipo_shift_stage #(.WIDTH(WIDTH)) u_shift (
    .shift_clk (shift_clk),
    .clr_n     (clr_n),
    .ser_in    (ser_in),
    .stage_q   (stage_q)
  );

  sipo_hold_reg #(.WIDTH(WIDTH)) u_hold (
    .latch_clk (latch_clk),
    .clr_n     (clr_n),
    .stage_in  (stage_q),
    .hold_q    (hold_q)
  );

  sipo_tri_drive #(.WIDTH(WIDTH)) u_drive (
    .oe_n   (oe_n),
    .hold_q (hold_q),
    .par_q  (par_q)
  );

  // cascade pin is never released to high impedance
  assign ser_out = stage_q[LAST];

  always_ff @(posedge shift_clk or negedge clr_n) begin
    if (!clr_n) begin
      casc_mark <= 1'b1;
    end else begin
      casc_mark <= 1'b0;
    end
  end

  assert_cascade_R8: assert property (@(posedge shift_clk) disable iff (!clr_n)
    !casc_mark |-> ser_out == $past(stage_q[LAST-1]));

endmodule

// File: tb/sim_dbl_buf_sipo.sv
module sim_dbl_buf_sipo;

  localparam int W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic ser_in, sclk, rclk, clr_n, oe_n;
  wire        mid, tail;
  tri1 [W-1:0] par_a;
  tri0 [W-1:0] par_b;

  dbl_buf_sipo #(.WIDTH(W)) u0 (
    .ser_in(ser_in), .shift_clk(sclk), .latch_clk(rclk), .clr_n(clr_n),
    .oe_n(oe_n), .par_q(par_a), .ser_out(mid)
  );

  dbl_buf_sipo #(.WIDTH(W)) u1 (
    .ser_in(mid), .shift_clk(sclk), .latch_clk(rclk), .clr_n(clr_n),
    .oe_n(oe_n), .par_q(par_b), .ser_out(tail)
  );

  logic [15:0] m;
  logic [15:0] h;
  int vectors = 0;
  int miscompares = 0;

  task automatic chk16(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_ser(input string req);
    chk16(req, {14'b0, tail, mid}, {14'b0, m[15], m[7]});
  endtask

  task automatic chk_par(input string req);
    chk16(req, {par_b, par_a}, h);
  endtask

  task automatic shift_bit(input logic b);
    ser_in = b;
    #2 sclk = 1'b1;
    m = {m[14:0], b};
    #3 sclk = 1'b0;
    #3;
  endtask

  task automatic latch();
    #1 rclk = 1'b1;
    h = m;
    #3 rclk = 1'b0;
    #4;
  endtask

  task automatic tied(input logic b);
    ser_in = b;
    #2 sclk = 1'b1; rclk = 1'b1;
    h = m;
    m = {m[14:0], b};
    #3 sclk = 1'b0; rclk = 1'b0;
    #3;
  endtask

  task automatic load_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) shift_bit(w[i]);
  endtask

  initial begin
    ser_in = 1'b0; sclk = 1'b0; rclk = 1'b0; oe_n = 1'b0; clr_n = 1'b1;
    m = '0; h = '0;
    #1 clr_n = 1'b0;
    #6;
    chk_ser("R5 reset state of cascade");
    clr_n = 1'b1;
    #4;
    latch();
    chk_par("R3 latch of cleared chain");

    // R1 R3 R4 R8 R10: sweep every upper byte with a derived lower byte
    for (int v = 0; v < 256; v++) begin
      logic [15:0] w;
      w = {8'(v), 8'(v * 37 + 11)};
      for (int i = 15; i >= 0; i--) begin
        shift_bit(w[i]);
        chk_ser("R1 R8 cascade follows shift");
      end
      chk_par("R4 outputs held during shifting");
      latch();
      chk16("R10 chained 16-bit load", {par_b, par_a}, w);
    end

    // R2: data change while clock high, then falling edge
    ser_in = 1'b1;
    #2 sclk = 1'b1;
    m = {m[14:0], 1'b1};
    #2 ser_in = 1'b0;
    #1 chk_ser("R2 value after rising edge");
    sclk = 1'b0;
    #3 chk_ser("R2 falling shift edge no change");

    // R4: shift while latch clock high, then falling latch edge
    #1 rclk = 1'b1;
    h = m;
    #2 shift_bit(1'b1);
    shift_bit(1'b0);
    rclk = 1'b0;
    #3 chk_par("R4 falling latch edge no change");

    // R5 R6: clear leaves the holding register, overrides the shift clock
    load_word(16'hC3A5);
    latch();
    chk_par("R3 preload before clear");
    clr_n = 1'b0;
    m = '0;
    #3 chk_ser("R5 asynchronous clear");
    chk_par("R6 clear leaves outputs");
    for (int i = 0; i < 3; i++) shift_bit(1'b1);
    m = '0;
    chk_ser("R5 shift blocked during clear");
    chk_par("R6 outputs kept during clear");
    clr_n = 1'b1;
    #4 latch();
    chk16("R5 cleared chain latched", {par_b, par_a}, 16'h0000);

    // R9: tied clocks keep the holding register one shift behind
    load_word(16'hBEEF);
    latch();
    for (int i = 15; i >= 0; i--) begin
      logic [15:0] pre;
      pre = m;
      tied(16'h1234 >> i);
      chk16("R9 tied clocks pre-shift capture", {par_b, par_a}, pre);
      chk_ser("R9 cascade on tied clocks");
    end

    // R7 R8: released outputs read the pull on each net
    load_word(16'hFF00);
    latch();
    chk_par("R7 driven when enabled");
    oe_n = 1'b1;
    #2 chk16("R7 high impedance reads pulls", {par_b, par_a}, 16'h00FF);
    load_word(16'h5A3C);
    chk_ser("R8 cascade driven while disabled");
    latch();
    chk16("R7 latch while disabled still floats", {par_b, par_a}, 16'h00FF);
    oe_n = 1'b0;
    #2 chk_par("R7 re-enabled shows new word");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog all requirements: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule